// File: doc/BRIEF.md
# Timing-Sequenced Accumulator Processor Core

This block is a minimal single-bus accumulator processor. A small state counter walks each instruction through numbered timing steps, and each step allows only a few register transfers. The core fetches a word from a word-addressed memory, decodes a three-bit operation field, and for the load operation moves the addressed operand into the accumulator through a data register and a pass-through ALU.

The address register is the only source of the memory address. The memory sits outside the core and answers a read in the same cycle, so each step that reads memory sees its word at once. A stop operation freezes the core so that a bench can tell when a program has finished. The program counter, accumulator, step counter, link flag and stop flag are brought out for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, pc, ac, step and link read 0, halted reads 0, and mem_addr reads 0, so the first fetch is from address 0.
- R2: In step 0 the address register takes the program counter, so mem_addr during step 1 equals the pc at the start of the instruction.
- R3: In step 1 the instruction register takes the word on mem_rdata, and pc rises by exactly one. pc changes in no other step.
- R4: In step 2 the address register takes instruction bits 11..0, so mem_addr during step 3 equals that operand field.
- R5: When instruction bits 14..12 equal 3'b010 (load), step 3 captures mem_rdata into the data register and step 4 copies it unchanged into ac. After the instruction, ac equals the memory word at the operand address. ac changes at no other time.
- R6: A load instruction occupies exactly five steps (0 to 4), and the step counter returns to 0 after step 4.
- R7: Any operation field other than 3'b010 and 3'b111 is a no-op: it occupies four steps (0 to 3), step returns to 0 after step 3, and ac is unchanged.
- R8: Operation field 3'b111 (stop) sets halted at the end of step 3. From then until reset, step stays at 3 and pc and ac hold their values.
- R9: Instruction bit 15 is ignored, so a load with bit 15 set behaves exactly like one with it clear.
- R10: The link flag is cleared by reset and no instruction in this set changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address, always the address register |
| mem_rdata | input | 16 | Memory read word, valid in the same cycle |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| sc | output | 3 | Current timing step |
| link | output | 1 | ALU link flag |
| halted | output | 1 | High once a stop instruction has run |

## Verification
A seeded random program mixes loads and no-ops with random operand addresses, operand data and bit 15. This shows whether the five-step and four-step paths are chosen by the operation field alone. Directed words cover cases that random draws rarely hit: an all-ones operand, a zero operand following it, and a load whose operand address is its own instruction word, which separates the operand read from the fetch read. A load with bit 15 set and a final stop, followed by a second reset, cover the ignored bit, the freeze and the restart from address 0.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  parameter int WORD_W = 16;
  parameter int ADDR_W = 12;
  parameter int OP_W   = 3;
  parameter int SC_W   = 3;
  localparam int OP_LSB = ADDR_W;
  localparam int IR_W   = OP_LSB + OP_W;

  typedef logic [OP_W-1:0] opcode_t;
  localparam opcode_t OP_LDA  = 3'b010;
  localparam opcode_t OP_HALT = 3'b111;

  typedef enum logic [SC_W-1:0] {T0, T1, T2, T3, T4} tstate_t;

  function automatic logic [ADDR_W-1:0] f_pc_next(input logic [ADDR_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  function automatic opcode_t f_opcode(input logic [IR_W-1:0] ir);
    return ir[IR_W-1:OP_LSB];
  endfunction

  function automatic logic [ADDR_W-1:0] f_operand(input logic [IR_W-1:0] ir);
    return ir[ADDR_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] f_alu_pass(input logic [WORD_W-1:0] d);
    return d;
  endfunction
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_t op,
  output tstate_t state,
  output logic    halted,
  output logic    ld_ar_pc,
  output logic    ld_ir,
  output logic    ld_ar_op,
  output logic    ld_dr,
  output logic    ld_ac
);
  logic run, halt_now, seq_clr;

  always_comb begin
    run      = !halted;
    ld_ar_pc = run && (state == T0);
    ld_ir    = run && (state == T1);
    ld_ar_op = run && (state == T2);
    ld_dr    = run && (state == T3) && (op == OP_LDA);
    ld_ac    = run && (state == T4);
    halt_now = run && (state == T3) && (op == OP_HALT);
    seq_clr  = run && ((state == T4) ||
               ((state == T3) && (op != OP_LDA) && (op != OP_HALT)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= T0;
      halted <= 1'b0;
    end else if (halt_now) begin
      halted <= 1'b1;
    end else if (run) begin
      if (seq_clr) state <= T0;
      else         state <= tstate_t'(state + 1'b1);
    end
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ar_pc,
  input  logic              ld_ir,
  input  logic              ld_ar_op,
  input  logic              ld_dr,
  input  logic              ld_ac,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] ac_q,
  output logic [IR_W-1:0]   ir_q,
  output logic              link_q
);
  logic [WORD_W-1:0] dr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q   <= '0;
      pc_q   <= '0;
      ac_q   <= '0;
      ir_q   <= '0;
      dr_q   <= '0;
      link_q <= 1'b0;
    end else begin
      if (ld_ar_pc)      ar_q <= pc_q;
      else if (ld_ar_op) ar_q <= f_operand(ir_q);
      if (ld_ir) begin
        ir_q <= mem_rdata[IR_W-1:0];
        pc_q <= f_pc_next(pc_q);
      end
      if (ld_dr) dr_q <= mem_rdata;
      if (ld_ac) ac_q <= f_alu_pass(dr_q);
      link_q <= link_q;
    end
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ac,
  output logic [SC_W-1:0]   sc,
  output logic              link,
  output logic              halted
);
  tstate_t           state;
  logic              ld_ar_pc, ld_ir, ld_ar_op, ld_dr, ld_ac;
  logic [IR_W-1:0]   ir_q;
  logic [ADDR_W-1:0] ar_q;
  opcode_t           dec_op;
  logic [ADDR_W-1:0] ir_operand;

  assign dec_op     = f_opcode(ir_q);
  assign ir_operand = f_operand(ir_q);

  acc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(dec_op), .state(state), .halted(halted),
    .ld_ar_pc(ld_ar_pc), .ld_ir(ld_ir), .ld_ar_op(ld_ar_op),
    .ld_dr(ld_dr), .ld_ac(ld_ac)
  );

  acc_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .ld_ar_pc(ld_ar_pc), .ld_ir(ld_ir),
    .ld_ar_op(ld_ar_op), .ld_dr(ld_dr), .ld_ac(ld_ac), .mem_rdata(mem_rdata),
    .ar_q(ar_q), .pc_q(pc), .ac_q(ac), .ir_q(ir_q), .link_q(link)
  );

  assign mem_addr = ar_q;
  assign sc       = state;
endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
  import acc_cpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] ac,
  input logic [SC_W-1:0]   sc,
  input logic              link,
  input logic              halted,
  input opcode_t           dec_op,
  input logic [ADDR_W-1:0] ir_operand
);
  AST_T0_ADDR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd0 && !halted) |=> mem_addr == $past(pc)); // R2
  AST_PC_STEP_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd1 && !halted) |=> pc == $past(pc) + 1'b1); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc != 3'd1) |=> $stable(pc)); // R3
  AST_T2_OPERAND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd2 && !halted) |=> mem_addr == $past(ir_operand)); // R4
  AST_AC_ONLY_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc != 3'd4) |=> $stable(ac)); // R5
  AST_LDA_TO_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd3 && !halted && dec_op == OP_LDA) |=> sc == 3'd4); // R6
  AST_SC_WRAP_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd4) |=> sc == 3'd0); // R6
  AST_NOP_WRAP_T3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd3 && !halted && dec_op != OP_LDA && dec_op != OP_HALT) |=> sc == 3'd0); // R7
  AST_HALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc == 3'd3 && dec_op == OP_HALT) |=> halted); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(sc) && $stable(pc) && $stable(ac)); // R8
  AST_LINK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(link)); // R10
endmodule

bind acc_cpu_core acc_cpu_core_chk u_chk (.*);

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
  localparam int N_PROG = 36;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr, pc;
  logic [15:0] mem_rdata, ac;
  logic [2:0]  sc;
  logic        link, halted;
  logic [15:0] mem [256];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_ac;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[7:0]];

  acc_cpu_core u_acc_cpu_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pc(pc), .ac(ac), .sc(sc), .link(link), .halted(halted)
  );

  function automatic bit is_load(input logic [15:0] w);
    return w[14:12] == 3'b010;
  endfunction
  function automatic int steps_of(input logic [15:0] w);
    return is_load(w) ? 5 : 4;
  endfunction
  function automatic logic [15:0] word(input bit b15, input int op, input int adr);
    return {b15, op[2:0], adr[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] w);
    logic [11:0] pc0;
    int n;
    pc0 = pc;
    chk(sc == 3'd0, "R6 start at step0", sc, 0);
    n = 1;
    forever begin
      @(negedge clk);
      if (sc == 3'd0) break;
      n++;
      if (sc == 3'd1) chk(mem_addr == pc0, "R2 fetch addr", mem_addr, pc0);
      if (sc == 3'd3) chk(mem_addr == w[11:0], "R4 operand addr", mem_addr, w[11:0]);
      if (n > 8) break;
    end
    if (is_load(w)) exp_ac = mem[w[7:0]];
    chk(n == steps_of(w), is_load(w) ? "R6 load steps" : "R7 noop steps", n, steps_of(w));
    chk(pc == pc0 + 12'd1, "R3 pc step", pc, pc0 + 12'd1);
    chk(ac == exp_ac, is_load(w) ? (w[15] ? "R9 load bit15" : "R5 ac value") : "R7 ac kept", ac, exp_ac);
  endtask

  task automatic check_reset_state(input string tag);
    chk(pc == 12'd0 && sc == 3'd0 && ac == 16'd0 && !halted && !link && mem_addr == 12'd0,
        tag, {pc, sc, halted}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 256; a++) mem[a] = 16'($urandom);
    mem[200] = 16'hFFFF;
    mem[201] = 16'h0000;
    mem[0] = word(1'b0, 2, 0);
    mem[1] = word(1'b0, 2, 200);
    mem[2] = word(1'b0, 2, 201);
    mem[3] = word(1'b1, 0, 130);
    mem[4] = word(1'b1, 2, 131);
    mem[5] = word(1'b0, 6, 132);
    for (int k = 6; k < N_PROG; k++) begin
      int op;
      if ($urandom % 4 == 0) begin
        do op = int'($urandom % 7); while (op == 2);
      end else op = 2;
      mem[k] = word(1'($urandom), op, 128 + int'($urandom % 128));
    end
    mem[N_PROG] = word(1'b0, 7, 0);
    exp_ac = 16'd0;

    repeat (3) @(negedge clk);
    check_reset_state("R1 reset state");
    rst_n = 1'b1;
    #1;
    check_reset_state("R1 after release");
    for (int k = 0; k < N_PROG; k++) run_instr(mem[k]);

    begin
      logic [11:0] pch;
      pch = pc;
      repeat (4) @(negedge clk);
      chk(halted == 1'b1, "R8 halted set", halted, 1);
      repeat (10) @(negedge clk);
      chk(halted && sc == 3'd3, "R8 step frozen", sc, 3);
      chk(pc == pch + 12'd1, "R8 pc frozen", pc, pch + 12'd1);
      chk(ac == exp_ac, "R8 ac frozen", ac, exp_ac);
      chk(link == 1'b0, "R10 link clear", link, 0);
    end
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1 second reset");
    rst_n = 1'b1;
    #1;
    exp_ac = 16'd0;
    run_instr(mem[0]);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule